// File: doc/BRIEF.md
# Nesting-Aware Prioritized Interrupt Controller

This block collects a set of system interrupt channels and presents them on two host request outputs: a fast host and a normal host. Each channel has its own enable, a priority and a host select. Within each host, the best pending, enabled and unmasked channel drives that host's request line, and the host's ID output gives the channel number. The host acknowledges with a one-cycle strobe. The strobe clears the pending bit of the channel shown on the ID output.

Support for nested handlers is built into the block. When automatic nesting is on, an acknowledge loads a nesting level from the priority of the acknowledged channel. Channels at that priority and below are then masked, so only strictly more urgent channels can preempt the running handler. The nesting level is either a single register shared by both hosts or one register per host. When the handler finishes, software writes the previous level back. A manual mode leaves the nesting registers under software control only.

All configuration is done with single-cycle register writes.

Top module: `nest_intc`

## Requirements
- R1: A rising edge on a channel input sets that channel's pending bit one clock later. The bit stays set after the input falls. An input that stays high does not set the bit again.
- R2: Writing address 3 clears every pending bit whose data bit is 1.
- R3: The enable register is at address 0, with bit n for channel n, and it resets to all zeros. A disabled channel does not request, but its pending bit is kept.
- R4: The host select register is at address 1. Bit n = 1 routes channel n to the fast host and bit n = 0 routes it to the normal host.
- R5: The priority of channel n is written at address 32+n, using data bits [3:0]. 0 is the most urgent priority. Within a host the lowest priority value wins, and a tie goes to the lowest channel number.
- R6: An acknowledge while that host is requesting clears the pending bit of the channel on its ID output in the same edge. An acknowledge while the host is not requesting changes nothing.
- R7: The mode register is at address 2, data bits [1:0]: 0 disabled, 1 automatic global, 2 automatic per host, 3 manual. It resets to 0. In mode 0 nothing is masked and acknowledges never update any nesting register.
- R8: In mode 1, an acknowledge on either host loads the global level with that channel's priority. The level masks channels whose priority is numerically greater than or equal to it, on both hosts. If both hosts acknowledge in the same cycle, the lower priority value is loaded, and on a tie the fast host's value is loaded.
- R9: In mode 2, each host has its own level. An acknowledge loads only the acknowledging host's level, and that level masks only that host's channels.
- R10: In mode 3, acknowledges never change any level, and the global level masks both hosts.
- R11: The level registers are at address 4 (global), address 5 (normal host) and address 6 (fast host). Data bit 4 marks the level active and bits [3:0] hold the priority. An inactive level, which is the reset value, masks nothing. When a software write and an acknowledge update the same level in one cycle, the software write wins.
- R12: Out of reset, no channel is pending, both request outputs are low and both ID outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_CH | Channel interrupt inputs |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | log2(N_CH)+1 | Register write address |
| wr_data_i | input | N_CH | Register write data |
| fast_ack_i | input | 1 | Acknowledge strobe for the fast host |
| norm_ack_i | input | 1 | Acknowledge strobe for the normal host |
| fast_req_o | output | 1 | Fast host request |
| fast_id_o | output | log2(N_CH) | Channel number of the winning fast-host channel |
| norm_req_o | output | 1 | Normal host request |
| norm_id_o | output | log2(N_CH) | Channel number of the winning normal-host channel |

## Verification
The assertions check the following on every cycle:
- A request always names a channel that is pending, enabled and routed to that host.
- An acknowledge clears the winning channel's pending bit.
- In global mode, the winner always ranks strictly above the active level.
- In global mode, a single acknowledge loads the winner's priority.
- In disabled and manual modes, the global level never moves without a write.
- Disabled mode never withholds a request.

Only the bench's scenarios can show the effects that need ordered stimulus:
- Tie-breaking across channel pairs.
- That a held input does not re-trigger.
- That a dual acknowledge loads the more urgent value.
- That a write beats an acknowledge in the same cycle.
- That per-host levels stay isolated.
- That a level left by manual mode persists across a pass through disabled mode.

// File: rtl/nest_pkg.sv
package nest_pkg;
  localparam int unsigned PRIO_W    = 4;
  localparam int unsigned HOSTS     = 2;
  localparam int unsigned HOST_NORM = 0;
  localparam int unsigned HOST_FAST = 1;

  typedef enum logic [1:0] {
    NEST_OFF    = 2'd0,
    NEST_GLOBAL = 2'd1,
    NEST_HOST   = 2'd2,
    NEST_MANUAL = 2'd3
  } nest_mode_e;

  // config addresses below the priority window
  localparam int unsigned A_EN       = 0;
  localparam int unsigned A_HSEL     = 1;
  localparam int unsigned A_MODE     = 2;
  localparam int unsigned A_CLR      = 3;
  localparam int unsigned A_LVL_GLB  = 4;
  localparam int unsigned A_LVL_HOST = 5; // + host index
endpackage

// File: rtl/intc_pend.sv
module intc_pend #(
  parameter int unsigned N_CH = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] src_i,
  input  logic [N_CH-1:0] clr_i,
  output logic [N_CH-1:0] pend_o
);
  logic [N_CH-1:0] src_q, pend_q, rise;

  assign rise   = src_i & ~src_q;
  assign pend_o = pend_q;

  // a fresh edge beats a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_i;
      pend_q <= (pend_q & ~clr_i) | rise;
    end
  end
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
  parameter int unsigned N_CH   = 32,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned ID_W  = $clog2(N_CH)
) (
  input  logic [N_CH-1:0]             cand_i,
  input  logic [N_CH-1:0][PRIO_W-1:0] prio_i,
  output logic                        req_o,
  output logic [ID_W-1:0]             id_o,
  output logic [PRIO_W-1:0]           prio_o
);
  // strict less-than keeps the lowest index on ties
  always_comb begin
    req_o  = 1'b0;
    id_o   = '0;
    prio_o = '0;
    for (int i = 0; i < int'(N_CH); i++) begin
      if (cand_i[i] && (!req_o || prio_i[i] < prio_o)) begin
        req_o  = 1'b1;
        id_o   = ID_W'(i);
        prio_o = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/intc_nest.sv
module intc_nest
  import nest_pkg::*;
#(
  parameter int unsigned N_CH   = 32,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [ADDR_W-1:0]                 wr_addr_i,
  input  logic [PRIO_W:0]                   wr_data_i,
  input  logic [HOSTS-1:0]                  fire_i,
  input  logic [HOSTS-1:0][PRIO_W-1:0]      fire_prio_i,
  input  logic [N_CH-1:0][PRIO_W-1:0]       prio_i,
  output nest_mode_e                        mode_o,
  output logic [PRIO_W:0]                   lvl_glb_o,
  output logic [HOSTS-1:0][N_CH-1:0]        mask_o
);
  // level format: {active, priority}
  localparam int unsigned LVL_W = PRIO_W + 1;

  nest_mode_e                    mode_q;
  logic [LVL_W-1:0]              glb_q;
  logic [HOSTS-1:0][LVL_W-1:0]   host_q;
  logic [PRIO_W-1:0]             glb_pick;

  assign mode_o    = mode_q;
  assign lvl_glb_o = glb_q;

  // dual acknowledge: more urgent value, fast host on a tie
  always_comb begin
    if (fire_i[HOST_FAST] && fire_i[HOST_NORM])
      glb_pick = (fire_prio_i[HOST_FAST] <= fire_prio_i[HOST_NORM]) ?
                 fire_prio_i[HOST_FAST] : fire_prio_i[HOST_NORM];
    else if (fire_i[HOST_FAST])
      glb_pick = fire_prio_i[HOST_FAST];
    else
      glb_pick = fire_prio_i[HOST_NORM];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= NEST_OFF;
      glb_q  <= '0;
    end else begin
      if (wr_en_i && wr_addr_i == ADDR_W'(A_MODE))
        mode_q <= nest_mode_e'(wr_data_i[1:0]);
      if (wr_en_i && wr_addr_i == ADDR_W'(A_LVL_GLB))
        glb_q <= wr_data_i;
      else if (mode_q == NEST_GLOBAL && |fire_i)
        glb_q <= {1'b1, glb_pick};
    end
  end

  for (genvar h = 0; h < int'(HOSTS); h++) begin : g_host
    logic [LVL_W-1:0] use_lvl;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        host_q[h] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(A_LVL_HOST + h))
        host_q[h] <= wr_data_i;
      else if (mode_q == NEST_HOST && fire_i[h])
        host_q[h] <= {1'b1, fire_prio_i[h]};
    end

    assign use_lvl = (mode_q == NEST_HOST) ? host_q[h] : glb_q;

    for (genvar c = 0; c < int'(N_CH); c++) begin : g_ch
      assign mask_o[h][c] = (mode_q != NEST_OFF) && use_lvl[PRIO_W] &&
                            (prio_i[c] >= use_lvl[PRIO_W-1:0]);
    end
  end
endmodule

// File: rtl/nest_intc.sv
module nest_intc
  import nest_pkg::*;
#(
  parameter int unsigned N_CH    = 32,
  parameter int unsigned PRIO_W  = nest_pkg::PRIO_W,
  localparam int unsigned ID_W   = $clog2(N_CH),
  localparam int unsigned ADDR_W = ID_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   src_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [N_CH-1:0]   wr_data_i,
  input  logic              fast_ack_i,
  input  logic              norm_ack_i,
  output logic              fast_req_o,
  output logic [ID_W-1:0]   fast_id_o,
  output logic              norm_req_o,
  output logic [ID_W-1:0]   norm_id_o
);
  logic [N_CH-1:0]              en_q, hsel_q, pend, clr;
  logic [N_CH-1:0][PRIO_W-1:0]  prio_q;
  logic [HOSTS-1:0]             ack, req, fire;
  logic [HOSTS-1:0][ID_W-1:0]   id;
  logic [HOSTS-1:0][PRIO_W-1:0] win_prio;
  logic [HOSTS-1:0][N_CH-1:0]   mask;
  logic [PRIO_W:0]              lvl_glb;
  nest_mode_e                   mode;

  assign ack[HOST_FAST] = fast_ack_i;
  assign ack[HOST_NORM] = norm_ack_i;
  assign fire           = ack & req;
  assign fast_req_o     = req[HOST_FAST];
  assign fast_id_o      = id[HOST_FAST];
  assign norm_req_o     = req[HOST_NORM];
  assign norm_id_o      = id[HOST_NORM];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      hsel_q <= '0;
      prio_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i[ADDR_W-1])
        prio_q[wr_addr_i[ID_W-1:0]] <= wr_data_i[PRIO_W-1:0];
      else if (wr_addr_i == ADDR_W'(A_EN))
        en_q <= wr_data_i;
      else if (wr_addr_i == ADDR_W'(A_HSEL))
        hsel_q <= wr_data_i;
    end
  end

  always_comb begin
    clr = (wr_en_i && wr_addr_i == ADDR_W'(A_CLR)) ? wr_data_i : '0;
    for (int h = 0; h < int'(HOSTS); h++)
      if (fire[h]) clr[id[h]] = 1'b1;
  end

  intc_pend #(.N_CH(N_CH)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  intc_nest #(.N_CH(N_CH), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_nest (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i[PRIO_W:0]),
    .fire_i      (fire),
    .fire_prio_i (win_prio),
    .prio_i      (prio_q),
    .mode_o      (mode),
    .lvl_glb_o   (lvl_glb),
    .mask_o      (mask)
  );

  for (genvar h = 0; h < int'(HOSTS); h++) begin : g_arb
    logic [N_CH-1:0] route, cand;
    assign route = (h == int'(HOST_FAST)) ? hsel_q : ~hsel_q;
    assign cand  = pend & en_q & route & ~mask[h];

    intc_arb #(.N_CH(N_CH), .PRIO_W(PRIO_W)) u_arb (
      .cand_i (cand),
      .prio_i (prio_q),
      .req_o  (req[h]),
      .id_o   (id[h]),
      .prio_o (win_prio[h])
    );
  end
endmodule

// File: rtl/nest_intc_chk.sv
module nest_intc_chk
  import nest_pkg::*;
#(
  parameter int unsigned N_CH   = 32,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned ID_W  = $clog2(N_CH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [N_CH-1:0]             src_i,
  input  logic                        fast_ack_i,
  input  logic                        norm_ack_i,
  input  logic                        fast_req_o,
  input  logic [ID_W-1:0]             fast_id_o,
  input  logic                        norm_req_o,
  input  logic [ID_W-1:0]             norm_id_o,
  input  logic [N_CH-1:0]             pend_i,
  input  logic [N_CH-1:0]             en_i,
  input  logic [N_CH-1:0]             hsel_i,
  input  logic [N_CH-1:0][PRIO_W-1:0] prio_i,
  input  logic [1:0]                  mode_i,
  input  logic [PRIO_W:0]             glb_i
);
  // R4
  fast_req_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_req_o |-> (pend_i[fast_id_o] && en_i[fast_id_o] && hsel_i[fast_id_o]));

  // R4
  norm_req_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    norm_req_o |-> (pend_i[norm_id_o] && en_i[norm_id_o] && !hsel_i[norm_id_o]));

  // R6
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_ack_i && fast_req_o && !src_i[fast_id_o]) |=> !pend_i[$past(fast_id_o)]);

  // R8
  glb_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && fast_ack_i && fast_req_o && !norm_ack_i && !wr_en_i)
    |=> glb_i == {1'b1, $past(prio_i[fast_id_o])});

  // R8
  glb_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && glb_i[PRIO_W] && fast_req_o)
    |-> prio_i[fast_id_o] < glb_i[PRIO_W-1:0]);

  // R10
  glb_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == 2'd0 || mode_i == 2'd3) && !wr_en_i) |=> $stable(glb_i));

  // R7
  off_no_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && |(pend_i & en_i & hsel_i)) |-> fast_req_o);
endmodule

bind nest_intc nest_intc_chk #(.N_CH(N_CH), .PRIO_W(PRIO_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .src_i      (src_i),
  .fast_ack_i (fast_ack_i),
  .norm_ack_i (norm_ack_i),
  .fast_req_o (fast_req_o),
  .fast_id_o  (fast_id_o),
  .norm_req_o (norm_req_o),
  .norm_id_o  (norm_id_o),
  .pend_i     (pend),
  .en_i       (en_q),
  .hsel_i     (hsel_q),
  .prio_i     (prio_q),
  .mode_i     (mode),
  .glb_i      (lvl_glb)
);

// File: tb/tb_nest_intc.sv
module tb_nest_intc;
  localparam int N = 32;
  localparam int NV = 7;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic        wr_en_i = 1'b0;
  logic [5:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        fast_ack_i = 1'b0, norm_ack_i = 1'b0;
  logic        fast_req_o, norm_req_o;
  logic [4:0]  fast_id_o, norm_id_o;
  int errs = 0, checks = 0;

  always #10 clk_i = ~clk_i;

  nest_intc #(.N_CH(N)) dut (.*);

  // {src, fast_req, fast_id, norm_req, norm_id}; priority of ch i = 15 - i/2, ch16..31 fast
  localparam logic [43:0] VEC [NV] = '{
    {32'h0000_0001, 1'b0, 5'd0,  1'b1, 5'd0},
    {32'h0000_0006, 1'b0, 5'd0,  1'b1, 5'd2},
    {32'h0003_0000, 1'b1, 5'd16, 1'b0, 5'd0},
    {32'h8000_8000, 1'b1, 5'd31, 1'b1, 5'd15},
    {32'h0000_0C00, 1'b0, 5'd0,  1'b1, 5'd10},
    {32'h5000_00F0, 1'b1, 5'd30, 1'b1, 5'd6},
    {32'h0000_0000, 1'b0, 5'd0,  1'b0, 5'd0}
  };

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(string r, logic ar, logic [4:0] ai, logic er, logic [4:0] ei);
    checks++;
    if (ar !== er || ai !== ei) begin
      errs++;
      $display("FAIL %s: req=%0b id=%0d expected req=%0b id=%0d", r, ar, ai, er, ei);
    end
  endtask

  task automatic chk_f(string r, logic er, logic [4:0] ei);
    chk({r, " fast"}, fast_req_o, fast_id_o, er, ei);
  endtask

  task automatic chk_n(string r, logic er, logic [4:0] ei);
    chk({r, " norm"}, norm_req_o, norm_id_o, er, ei);
  endtask

  task automatic wr(int a, logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = 6'(a); wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic pulse(logic [31:0] m);
    src_i = m;
    tick();
    src_i = '0;
  endtask

  task automatic ack(logic f, logic n);
    fast_ack_i = f; norm_ack_i = n;
    tick();
    fast_ack_i = 1'b0; norm_ack_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errs++; checks++;
    $display("FAIL watchdog: run=hung expected=done");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk_f("R12 reset", 1'b0, 5'd0);
    chk_n("R12 reset", 1'b0, 5'd0);
    rst_ni = 1'b1;
    tick();
    pulse(32'h1);
    chk_n("R3 R12 enable reset zero", 1'b0, 5'd0);
    wr(0, 32'hFFFF_FFFF);
    chk_n("R3 pending kept while disabled", 1'b1, 5'd0);
    wr(3, 32'hFFFF_FFFF);
    wr(1, 32'hFFFF_0000);
    for (int i = 0; i < N; i++) wr(32 + i, 32'(15 - i / 2));

    // R5 R4 R1 table
    for (int v = 0; v < NV; v++) begin
      pulse(VEC[v][43:12]);
      chk_f($sformatf("R5 vec%0d", v), VEC[v][11], VEC[v][10:6]);
      chk_n($sformatf("R5 vec%0d", v), VEC[v][5], VEC[v][4:0]);
      wr(3, 32'hFFFF_FFFF);
    end

    // R1 held input does not retrigger
    src_i = 32'h8;
    tick();
    chk_n("R1 edge", 1'b1, 5'd3);
    ack(1'b0, 1'b1);
    chk_n("R1 R6 held no retrigger", 1'b0, 5'd0);
    src_i = '0;
    tick();
    pulse(32'h8);
    repeat (3) tick();
    chk_n("R1 persists", 1'b1, 5'd3);

    // R3
    wr(0, ~32'h8);
    chk_n("R3 disabled", 1'b0, 5'd0);
    wr(0, 32'hFFFF_FFFF);
    chk_n("R3 reenabled", 1'b1, 5'd3);

    // R2
    pulse(32'h1);
    wr(3, 32'h8);
    chk_n("R2 clear", 1'b1, 5'd0);
    wr(3, 32'hFFFF_FFFF);

    // R4 host select flip
    wr(1, 32'hFFFF_0001);
    pulse(32'h1);
    chk_f("R4 to fast", 1'b1, 5'd0);
    chk_n("R4 to fast", 1'b0, 5'd0);
    wr(1, 32'hFFFF_0000);
    chk_n("R4 back to norm", 1'b1, 5'd0);
    wr(3, 32'hFFFF_FFFF);

    // R6 ack without request, global mode
    wr(2, 1);
    ack(1'b1, 1'b0);
    pulse(32'h1);
    chk_n("R6 R11 idle ack ignored", 1'b1, 5'd0);
    wr(3, 32'hFFFF_FFFF);

    // R8 global nesting
    pulse(32'h0010_0100);
    chk_f("R8 before ack", 1'b1, 5'd20);
    ack(1'b1, 1'b0);
    chk_n("R8 masked other host", 1'b0, 5'd0);
    pulse(32'h4000_0000);
    chk_f("R8 higher preempts", 1'b1, 5'd30);
    pulse(32'h0000_4000);
    chk_n("R8 lower masked", 1'b0, 5'd0);
    wr(4, 0);
    chk_n("R11 restore", 1'b1, 5'd14);
    wr(3, 32'hFFFF_FFFF);

    // R8 dual acknowledge
    pulse(32'h0400_8000);
    ack(1'b1, 1'b1);
    pulse(32'h0040_0000);
    chk_f("R8 dual ack loads more urgent", 1'b0, 5'd0);
    pulse(32'h1000_0000);
    chk_f("R8 strictly higher", 1'b1, 5'd28);
    wr(4, 0);
    wr(3, 32'hFFFF_FFFF);

    // R11 write beats ack
    wr(4, 32'h15);
    pulse(32'h8000_0000);
    chk_f("R11 level 5", 1'b1, 5'd31);
    wr_en_i = 1'b1; wr_addr_i = 6'd4; wr_data_i = '0; fast_ack_i = 1'b1;
    tick();
    wr_en_i = 1'b0; fast_ack_i = 1'b0;
    pulse(32'h100);
    chk_n("R11 write wins", 1'b1, 5'd8);
    wr(3, 32'hFFFF_FFFF);

    // R9 per-host
    wr(2, 2);
    pulse(32'h0010_0100);
    ack(1'b1, 1'b0);
    chk_n("R9 other host free", 1'b1, 5'd8);
    pulse(32'h0020_0000);
    chk_f("R9 own host masked", 1'b0, 5'd0);
    pulse(32'h0400_0000);
    chk_f("R9 higher passes", 1'b1, 5'd26);
    ack(1'b0, 1'b1);
    chk_f("R9 norm ack leaves fast", 1'b1, 5'd26);
    wr(3, 32'hFFFF_FFFF);
    wr(5, 0);
    wr(6, 0);

    // R10 manual
    wr(2, 3);
    pulse(32'h0010_0000);
    ack(1'b1, 1'b0);
    pulse(32'h0020_0000);
    chk_f("R10 ack no update", 1'b1, 5'd21);
    wr(4, 32'h16);
    chk_f("R10 level above", 1'b1, 5'd21);
    wr(4, 32'h15);
    chk_f("R10 R11 equal masked", 1'b0, 5'd0);

    // R7 off
    wr(2, 0);
    chk_f("R7 off no mask", 1'b1, 5'd21);
    pulse(32'h8000_0000);
    ack(1'b1, 1'b0);
    chk_f("R7 ack in off", 1'b1, 5'd21);
    wr(2, 1);
    chk_f("R7 level kept", 1'b0, 5'd0);
    pulse(32'h0400_0000);
    chk_f("R7 no update in off", 1'b1, 5'd26);

    report();
    $finish;
  end
endmodule